// File: doc/BRIEF.md
# Pseudo-Associative Read Cache

This block is a read-only cache built on one direct-mapped tag/data array. Each line may sit at one of two places: its home slot, chosen by the index bits of the address, or its partner slot, which is the home index with its top bit inverted. A request that misses at home gets a second look at the partner slot before memory is asked. A line found at the partner slot is a pseudo-hit. It is then exchanged with the home occupant, so the next access to it is a fast hit.

Each entry stores a valid bit, a flag marking that it lives at its partner slot, the tag, and one data word. The flag is part of the match, so a line parked at its partner slot can never answer for an address whose home is that slot.

True misses go out on a simple fill port: a one-cycle request pulse carrying the full address, and a one-cycle data return. The new line is placed at home and the previous home occupant is pushed to the partner slot. A CPU-side master issues one request while `req_ready` is high and waits for `resp_valid`. Each response carries the data and a status: fast, pseudo or miss.

Top module: `pac_cache`

## Requirements
- R1: While reset is low at a clock edge, the block leaves that edge with `req_ready` high, `resp_valid` low and `mem_req_valid` low, and every line becomes invalid, so the first access to any address after reset is a miss.
- R2: A request whose line sits valid at its home index with the partner flag clear returns status 2'b01 (fast) and the line's data one cycle after acceptance, with no memory request.
- R3: On a home miss, the entry at the home index with its top bit inverted is checked; if it is valid, has the partner flag set and its tag matches, status 2'b10 (pseudo) and its data are returned two cycles after acceptance, with no memory request.
- R4: After a pseudo-hit, the used line and the home occupant exchange slots: the same address then gives a fast hit, and the former home occupant answers as a pseudo-hit.
- R5: When both probes fail, `mem_req_valid` is high for exactly one cycle, two cycles after acceptance, with `mem_req_addr` equal to the request address. The response, status 2'b11 (miss) with the returned memory word, comes in the cycle after `mem_resp_valid`.
- R6: A fill writes the new line at its home index. A valid previous home occupant is moved to the partner slot and whatever was there is lost, so it misses next time. If the home slot was empty, the partner slot keeps its line.
- R7: A line parked at its partner slot never gives a fast hit for another address that has the same tag and whose home index is that slot.
- R8: `req_ready` is low from the cycle after a slow acceptance until the response cycle, and it is high in every response cycle; `mem_req_valid` is never high while `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | CPU read request present |
| req_addr | input | ADDR_W | Word address of the request |
| req_ready | output | 1 | Block idle and accepting a request |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_data | output | DATA_W | Data word of the response |
| resp_status | output | 2 | 01 fast, 10 pseudo, 11 miss |
| mem_req_valid | output | 1 | One-cycle fill request pulse |
| mem_req_addr | output | ADDR_W | Address being fetched |
| mem_resp_valid | input | 1 | Fill data present this cycle |
| mem_resp_data | input | DATA_W | Fill data word |

## Verification
The bound checker watches the handshake shape on every cycle. It checks that a fast response follows an acceptance by one cycle and a pseudo response by two, that a miss response follows returned fill data, that the fill request is a single pulse, and that ready is high whenever a response comes out. Correct data, the choice of status, the slot exchange after a pseudo-hit, the eviction order on fills and the partner-flag disambiguation depend on what the array holds. Only the bench's scenarios can show these, by comparing each response against a reference placement model.

// File: rtl/pac_pkg.sv
// Package pac_pkg: shared types and codes of the pseudo-associative cache.
// Assumes nothing beyond IEEE 1800-2017 packages.
package pac_pkg;

    // Response status codes seen on resp_status
    localparam logic [1:0] ST_FAST   = 2'b01;
    localparam logic [1:0] ST_PSEUDO = 2'b10;
    localparam logic [1:0] ST_MISS   = 2'b11;

    // Controller states
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_PROBE = 2'd1,
        S_REQ   = 2'd2,
        S_WAIT  = 2'd3
    } pac_state_e;

endpackage

// File: rtl/pac_array.sv
// Module pac_array: line storage with two combinational read ports and two
// write ports. An entry is packed as {valid, partner flag, tag, data}.
// Assumes the two write ports never target the same index in one cycle;
// only valid bits are reset, tag and data are left as they are.
module pac_array #(
    parameter int TAG_W  = 12,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [IDX_W-1:0]              ra_idx,
    output logic [2+TAG_W+DATA_W-1:0]     ra_ent,
    input  logic [IDX_W-1:0]              rb_idx,
    output logic [2+TAG_W+DATA_W-1:0]     rb_ent,
    input  logic                          wa_en,
    input  logic [IDX_W-1:0]              wa_idx,
    input  logic [2+TAG_W+DATA_W-1:0]     wa_ent,
    input  logic                          wb_en,
    input  logic [IDX_W-1:0]              wb_idx,
    input  logic [2+TAG_W+DATA_W-1:0]     wb_ent
);
    localparam int DEPTH = 1 << IDX_W;
    localparam int ENT_W = 2 + TAG_W + DATA_W;

    logic [DEPTH-1:0]  vld_vec;
    logic [DEPTH-1:0]  alt_vec;
    logic [TAG_W-1:0]  tag_arr  [DEPTH];
    logic [DATA_W-1:0] data_arr [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        logic              vld_r;
        logic              alt_r;
        logic [TAG_W-1:0]  tag_r;
        logic [DATA_W-1:0] data_r;
        logic              hit_a;
        logic              hit_b;

        assign hit_a = wa_en && (wa_idx == IDX_W'(g));
        assign hit_b = wb_en && (wb_idx == IDX_W'(g));

        // Valid bit: cleared by reset, loaded by whichever port targets it
        always_ff @(posedge clk) begin
            if (!rst_n)
                vld_r <= 1'b0;
            else if (hit_a)
                vld_r <= wa_ent[ENT_W-1];
            else if (hit_b)
                vld_r <= wb_ent[ENT_W-1];
        end

        // Flag, tag and data: plain storage without reset
        always_ff @(posedge clk) begin
            if (hit_a) begin
                alt_r  <= wa_ent[ENT_W-2];
                tag_r  <= wa_ent[DATA_W +: TAG_W];
                data_r <= wa_ent[DATA_W-1:0];
            end else if (hit_b) begin
                alt_r  <= wb_ent[ENT_W-2];
                tag_r  <= wb_ent[DATA_W +: TAG_W];
                data_r <= wb_ent[DATA_W-1:0];
            end
        end

        assign vld_vec[g]  = vld_r;
        assign alt_vec[g]  = alt_r;
        assign tag_arr[g]  = tag_r;
        assign data_arr[g] = data_r;
    end

    // Read ports: combinational lookup of both probe slots
    always_comb begin
        ra_ent = {vld_vec[ra_idx], alt_vec[ra_idx], tag_arr[ra_idx], data_arr[ra_idx]};
        rb_ent = {vld_vec[rb_idx], alt_vec[rb_idx], tag_arr[rb_idx], data_arr[rb_idx]};
    end

endmodule

// File: rtl/pac_probe.sv
// Module pac_probe: match logic for one slot. A slot matches when it is valid,
// its partner flag equals the flag expected for this slot, and the tag agrees.
// Assumes the header is packed as {valid, partner flag, tag}.
module pac_probe #(
    parameter int TAG_W = 12
) (
    input  logic [2+TAG_W-1:0] hdr,
    input  logic [TAG_W-1:0]   tag,
    input  logic               want_alt,
    output logic               hit
);
    logic              h_vld;
    logic              h_alt;
    logic [TAG_W-1:0]  h_tag;

    // Split the header and compare flag and tag together
    always_comb begin
        {h_vld, h_alt, h_tag} = hdr;
        hit = h_vld && (h_alt == want_alt) && (h_tag == tag);
    end

endmodule

// File: rtl/pac_ctrl.sv
// Module pac_ctrl: sequencing of the cache. Idle accepts a request and
// resolves a home hit in the same cycle; otherwise it walks through the
// partner probe, the fill request and the wait for fill data. It owns the
// response strobe and status. Assumes memory answers at least one cycle
// after the request pulse.
module pac_ctrl
    import pac_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       prim_hit,
    input  logic       alt_hit,
    input  logic       mem_resp_valid,
    output logic       req_ready,
    output logic       accept,
    output logic       swap_en,
    output logic       fill_en,
    output logic       mem_req_valid,
    output logic       resp_valid,
    output logic [1:0] resp_status
);
    pac_state_e state_q, state_d;

    // Decode of the current state into strobes
    always_comb begin
        req_ready     = (state_q == S_IDLE);
        accept        = req_ready && req_valid;
        swap_en       = (state_q == S_PROBE) && alt_hit;
        fill_en       = (state_q == S_WAIT) && mem_resp_valid;
        mem_req_valid = (state_q == S_REQ);
    end

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (req_valid && !prim_hit) state_d = S_PROBE;
            S_PROBE: state_d = alt_hit ? S_IDLE : S_REQ;
            S_REQ:   state_d = S_WAIT;
            S_WAIT:  if (mem_resp_valid) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    // Response strobe and status register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid  <= 1'b0;
            resp_status <= ST_FAST;
        end else begin
            resp_valid <= (accept && prim_hit) || swap_en || fill_en;
            if (accept && prim_hit)
                resp_status <= ST_FAST;
            else if (swap_en)
                resp_status <= ST_PSEUDO;
            else if (fill_en)
                resp_status <= ST_MISS;
        end
    end

endmodule

// File: rtl/pac_cache.sv
// Module pac_cache: top of the pseudo-associative read cache. It keeps the
// request in flight, steers the two array ports (home slot and partner slot),
// builds the entries written on an exchange or a fill, and holds response
// data. Assumes one outstanding request and word-sized lines.
module pac_cache #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              resp_valid,
    output logic [DATA_W-1:0] resp_data,
    output logic [1:0]        resp_status,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_resp_valid,
    input  logic [DATA_W-1:0] mem_resp_data
);
    localparam int TAG_W = ADDR_W - IDX_W;
    localparam int HDR_W = 2 + TAG_W;
    localparam int ENT_W = HDR_W + DATA_W;
    localparam logic [IDX_W-1:0] FLIP = IDX_W'(1) << (IDX_W - 1);

    logic [ADDR_W-1:0] cur_addr;
    logic [IDX_W-1:0]  cur_idx;
    logic [IDX_W-1:0]  cur_pidx;
    logic [TAG_W-1:0]  cur_tag;
    logic [IDX_W-1:0]  req_idx;
    logic [TAG_W-1:0]  req_tag;

    logic [IDX_W-1:0]  ra_idx;
    logic [TAG_W-1:0]  pa_tag;
    logic [ENT_W-1:0]  ra_ent;
    logic [ENT_W-1:0]  rb_ent;
    logic              wa_en;
    logic              wb_en;
    logic [ENT_W-1:0]  wa_ent;
    logic [ENT_W-1:0]  wb_ent;

    logic              prim_hit;
    logic              alt_hit;
    logic              accept;
    logic              swap_en;
    logic              fill_en;

    // Address fields of the incoming and the in-flight request
    always_comb begin
        req_idx  = req_addr[IDX_W-1:0];
        req_tag  = req_addr[ADDR_W-1:IDX_W];
        cur_idx  = cur_addr[IDX_W-1:0];
        cur_tag  = cur_addr[ADDR_W-1:IDX_W];
        cur_pidx = cur_idx ^ FLIP;
    end

    // Home port follows the bus when idle and the held request otherwise
    always_comb begin
        ra_idx = req_ready ? req_idx : cur_idx;
        pa_tag = req_ready ? req_tag : cur_tag;
    end

    // In-flight request register
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur_addr <= '0;
        else if (accept)
            cur_addr <= req_addr;
    end

    // Entries written: new or promoted line at home, old home line to partner
    always_comb begin
        wa_en  = swap_en || fill_en;
        wa_ent = {1'b1, 1'b0, cur_tag,
                  swap_en ? rb_ent[DATA_W-1:0] : mem_resp_data};
        wb_en  = swap_en || (fill_en && ra_ent[ENT_W-1]);
        wb_ent = {ra_ent[ENT_W-1], ~ra_ent[ENT_W-2], ra_ent[ENT_W-3:0]};
    end

    // Response data register, chosen by which path answered
    always_ff @(posedge clk) begin
        if (!rst_n)
            resp_data <= '0;
        else if (accept && prim_hit)
            resp_data <= ra_ent[DATA_W-1:0];
        else if (swap_en)
            resp_data <= rb_ent[DATA_W-1:0];
        else if (fill_en)
            resp_data <= mem_resp_data;
    end

    assign mem_req_addr = cur_addr;

    pac_array #(
        .TAG_W  (TAG_W),
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_array (
        .clk    (clk),
        .rst_n  (rst_n),
        .ra_idx (ra_idx),
        .ra_ent (ra_ent),
        .rb_idx (cur_pidx),
        .rb_ent (rb_ent),
        .wa_en  (wa_en),
        .wa_idx (cur_idx),
        .wa_ent (wa_ent),
        .wb_en  (wb_en),
        .wb_idx (cur_pidx),
        .wb_ent (wb_ent)
    );

    pac_probe #(.TAG_W(TAG_W)) u_probe_home (
        .hdr      (ra_ent[ENT_W-1:DATA_W]),
        .tag      (pa_tag),
        .want_alt (1'b0),
        .hit      (prim_hit)
    );

    pac_probe #(.TAG_W(TAG_W)) u_probe_partner (
        .hdr      (rb_ent[ENT_W-1:DATA_W]),
        .tag      (cur_tag),
        .want_alt (1'b1),
        .hit      (alt_hit)
    );

    pac_ctrl u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .prim_hit       (prim_hit),
        .alt_hit        (alt_hit),
        .mem_resp_valid (mem_resp_valid),
        .req_ready      (req_ready),
        .accept         (accept),
        .swap_en        (swap_en),
        .fill_en        (fill_en),
        .mem_req_valid  (mem_req_valid),
        .resp_valid     (resp_valid),
        .resp_status    (resp_status)
    );

endmodule

// File: rtl/pac_cache_chk.sv
// Module pac_cache_chk: protocol checker bound to pac_cache. It checks the
// response timing per status class and the shape of the fill request.
module pac_cache_chk
    import pac_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic       resp_valid,
    input logic [1:0] resp_status,
    input logic       mem_req_valid,
    input logic       mem_resp_valid
);
    // R2: a fast answer follows an acceptance by one cycle
    a_r2_fast_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_status == ST_FAST) |-> $past(req_valid && req_ready));

    // R3: a pseudo answer follows a busy probe cycle and an acceptance before it
    a_r3_pseudo_two_cycles: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_status == ST_PSEUDO)
            |-> ($past(!req_ready) && $past(req_valid && req_ready, 2)));

    // R5: a miss answer follows returned fill data
    a_r5_miss_after_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_status == ST_MISS)
            |-> ($past(mem_resp_valid) && $past(!req_ready)));

    // R5: the fill request is a single-cycle pulse
    a_r5_mem_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid);

    // R8: the block is idle in every response cycle
    a_r8_ready_on_resp: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> req_ready);

    // R8: no fill request while accepting
    a_r8_busy_on_mem_req: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready);

endmodule

bind pac_cache pac_cache_chk u_pac_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .resp_valid     (resp_valid),
    .resp_status    (resp_status),
    .mem_req_valid  (mem_req_valid),
    .mem_resp_valid (mem_resp_valid)
);

// File: tb/tb_pac_cache.sv
// Bench for pac_cache: a reference placement model predicts the status of
// every read; memory returns a word computed from the address.
module tb_pac_cache;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;
    localparam int IDX_W  = 4;
    localparam int TAG_W  = ADDR_W - IDX_W;
    localparam int DEPTH  = 1 << IDX_W;
    localparam logic [IDX_W-1:0] FLIP = IDX_W'(1) << (IDX_W - 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              req_ready;
    logic              resp_valid;
    logic [DATA_W-1:0] resp_data;
    logic [1:0]        resp_status;
    logic              mem_req_valid;
    logic [ADDR_W-1:0] mem_req_addr;
    logic              mem_resp_valid = 1'b0;
    logic [DATA_W-1:0] mem_resp_data = '0;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    // Reference model of placement
    bit               m_vld [DEPTH];
    bit               m_alt [DEPTH];
    logic [TAG_W-1:0] m_tag [DEPTH];

    pac_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready), .resp_valid(resp_valid), .resp_data(resp_data),
        .resp_status(resp_status), .mem_req_valid(mem_req_valid),
        .mem_req_addr(mem_req_addr), .mem_resp_valid(mem_resp_valid),
        .mem_resp_data(mem_resp_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [DATA_W-1:0] mem_word(input logic [ADDR_W-1:0] a);
        return {a, ~a} ^ 32'h5A3C_96E1;
    endfunction

    function automatic logic [ADDR_W-1:0] mk_addr(input int tag, input int idx);
        return {TAG_W'(tag), IDX_W'(idx)};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Predict status and update the model (statuses: 1 fast, 2 pseudo, 3 miss)
    task automatic predict(input logic [ADDR_W-1:0] a, output int st);
        logic [IDX_W-1:0] i, p;
        logic [TAG_W-1:0] t;
        i = a[IDX_W-1:0];
        t = a[ADDR_W-1:IDX_W];
        p = i ^ FLIP;
        if (m_vld[i] && !m_alt[i] && m_tag[i] == t) begin
            st = 1;
        end else if (m_vld[p] && m_alt[p] && m_tag[p] == t) begin
            st = 2;
            m_vld[p] = m_vld[i]; m_alt[p] = ~m_alt[i]; m_tag[p] = m_tag[i];
            m_vld[i] = 1; m_alt[i] = 0; m_tag[i] = t;
        end else begin
            st = 3;
            if (m_vld[i]) begin
                m_vld[p] = 1; m_alt[p] = ~m_alt[i]; m_tag[p] = m_tag[i];
            end
            m_vld[i] = 1; m_alt[i] = 0; m_tag[i] = t;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        req_valid = 1'b0;
        mem_resp_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready in reset", 32'(req_ready), 1);
        chk(resp_valid == 1'b0, "R1 resp in reset", 32'(resp_valid), 0);
        chk(mem_req_valid == 1'b0, "R1 memreq in reset", 32'(mem_req_valid), 0);
        for (int k = 0; k < DEPTH; k++) m_vld[k] = 0;
        rst_n = 1'b1;
    endtask

    // One read with its memory side; checks status, data, timing, fill port
    task automatic do_read(input logic [ADDR_W-1:0] a, input int lat,
                           input string tag_s);
        int st, cyc, reqcyc, memcnt, explat;
        bit got;
        string rq;
        predict(a, st);
        rq = (st == 1) ? "R2" : (st == 2) ? "R3" : "R5";
        explat = (st == 1) ? 1 : (st == 2) ? 2 : 3 + lat;
        @(negedge clk);
        chk(req_ready == 1'b1, {"R8 ready at issue ", tag_s}, 32'(req_ready), 1);
        req_valid = 1'b1;
        req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 1; reqcyc = -1; memcnt = 0; got = 0;
        while (!got && cyc < 80) begin
            mem_resp_valid = 1'b0;
            if (resp_valid) begin
                got = 1;
            end else begin
                chk(req_ready == 1'b0, {"R8 busy ", tag_s}, 32'(req_ready), 0);
                if (mem_req_valid) begin
                    memcnt++;
                    if (reqcyc < 0) reqcyc = cyc;
                    chk(mem_req_addr == a, {"R5 mem addr ", tag_s},
                        32'(mem_req_addr), 32'(a));
                end
                if (reqcyc >= 0 && cyc == reqcyc + lat) begin
                    mem_resp_valid = 1'b1;
                    mem_resp_data = mem_word(mem_req_addr);
                end
                @(negedge clk);
                cyc++;
            end
        end
        mem_resp_valid = 1'b0;
        chk(got && cyc == explat, {rq, " latency ", tag_s}, 32'(cyc), 32'(explat));
        chk(32'(resp_status) == 32'(st), {rq, " status ", tag_s},
            32'(resp_status), 32'(st));
        chk(resp_data == mem_word(a), {rq, " data ", tag_s}, resp_data, mem_word(a));
        chk(req_ready == 1'b1, {"R8 ready on resp ", tag_s}, 32'(req_ready), 1);
        chk(memcnt == ((st == 3) ? 1 : 0), {"R5 mem pulses ", tag_s},
            32'(memcnt), (st == 3) ? 1 : 0);
        if (st == 3)
            chk(reqcyc == 2, {"R5 mem req cycle ", tag_s}, 32'(reqcyc), 2);
    endtask

    // Read whose status is also pinned to a directed expectation
    task automatic expect_read(input logic [ADDR_W-1:0] a, input int want,
                               input string tag_s);
        int st_pre;
        logic [IDX_W-1:0] i, p;
        logic [TAG_W-1:0] t;
        i = a[IDX_W-1:0];
        t = a[ADDR_W-1:IDX_W];
        p = i ^ FLIP;
        st_pre = (m_vld[i] && !m_alt[i] && m_tag[i] == t) ? 1 :
                 (m_vld[p] && m_alt[p] && m_tag[p] == t) ? 2 : 3;
        chk(st_pre == want, {tag_s, " model expectation"}, 32'(st_pre), 32'(want));
        do_read(a, 2, tag_s);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        // R1: cold array misses
        expect_read(mk_addr(1, 3), 3, "R1 cold miss");
        // R2: repeat gives fast hit
        expect_read(mk_addr(1, 3), 1, "R2 repeat");
        // R6: second line at same home pushes first to partner
        expect_read(mk_addr(2, 3), 3, "R6 push");
        // R3: first line now answers from partner slot
        expect_read(mk_addr(1, 3), 2, "R3 pseudo");
        // R4: exchanged lines
        expect_read(mk_addr(1, 3), 1, "R4 promoted");
        expect_read(mk_addr(2, 3), 2, "R4 demoted");
        // R7: same tag, home index equal to the parked slot -> not a hit
        expect_read(mk_addr(2, 3), 1, "R7 setup");
        expect_read(mk_addr(1, 3 ^ 8), 3, "R7 parked alias");
        // R6: a third line evicts the partner occupant
        do_reset();
        expect_read(mk_addr(1, 5), 3, "R6 a");
        expect_read(mk_addr(2, 5), 3, "R6 b");
        expect_read(mk_addr(3, 5), 3, "R6 c");
        expect_read(mk_addr(2, 5), 2, "R6 b kept");
        expect_read(mk_addr(1, 5), 3, "R6 a lost");
        // R6: empty home leaves partner line in place
        do_reset();
        expect_read(mk_addr(5, 11), 3, "R6 x");
        expect_read(mk_addr(6, 3), 3, "R6 y");
        expect_read(mk_addr(5, 11), 1, "R6 x kept");
        // R1: reset mid-run invalidates lines
        do_reset();
        expect_read(mk_addr(6, 3), 3, "R1 after reset");
        // Random mix over a small address set
        for (int n = 0; n < 400; n++) begin
            do_read(mk_addr(int'($urandom_range(0, 2)), int'($urandom_range(0, DEPTH-1))),
                    int'($urandom_range(1, 4)), "random");
        end
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures",
                     n_checks, n_fails);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures",
                     n_checks, n_fails);
            $finish;
        end
    end

endmodule